// File: doc/BRIEF.md
# Single-Cycle Load/Store Datapath

This block is a 32-bit datapath that completes one instruction on every clock edge. A program counter addresses a word-organised instruction array. The fetched word is split by fixed bit slices into register selectors, a function code and a 16-bit immediate. A decoder turns the opcode and function code into control bits. The control bits steer a two-read, one-write register file, a four-operation ALU, a sign extender, a data array and a branch-target adder. The instructions it supports are the register-to-register add, subtract, AND and OR, a word load, a word store and branch-if-equal.

Both arrays are filled through a load port, normally while reset is held. Reset clears the program counter and the register file but leaves both arrays intact. An observation port reads any register without a clock edge. A harness can therefore run a program and inspect the architectural state at each step.

Top module: `rdp_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0x00000000 and every register reads zero after that edge.
- R2: Register 0 always reads zero, and any instruction that names it as destination leaves it at zero.
- R3: For every instruction except a taken branch, the program counter advances by 4 on each edge. The instruction fetched is the array word at index `pc[MAW+1:2]`.
- R4: Opcode 0x00 with shamt (bits 10:6) zero and funct (bits 5:0) 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt, modulo 2^32, into register rd. Here rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11.
- R5: Opcode 0x00 with any other funct, or with a nonzero shamt, writes no register.
- R6: Opcode 0x23 loads the data word at byte address rs + sign-extended bits 15:0 into register rt.
- R7: Opcode 0x2B stores register rt into the data word at byte address rs + sign-extended bits 15:0 and writes no register.
- R8: Opcode 0x04 writes nothing. When rs equals rt, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2, so backward targets work too. Otherwise the next PC is PC+4.
- R9: Any other opcode changes no register and no data word; only the PC advances.
- R10: With `ld_en` high at an edge, `ld_data` is written to word `ld_addr` of the data array when `ld_dmem` is 1, or of the instruction array when it is 0. Reset does not clear either array.
- R11: `obs_data` shows, combinationally, the current value of register `obs_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write enable of the array load port |
| ld_dmem | input | 1 | Load target: 1 data array, 0 instruction array |
| ld_addr | input | $clog2(MEM_WORDS) | Word index written by the load port |
| ld_data | input | 32 | Word written by the load port |
| obs_sel | input | 5 | Register selected for observation |
| obs_data | output | 32 | Value of the observed register |
| pc | output | 32 | Current program counter |

## Verification
The bench uses the default `MEM_WORDS` of 64. With that depth a 22-word program and a full 64-word data image fit. Load and store addresses of 8, 12, 60 and 100 all index distinct words, and a backward branch of -16 words from word 21 returns inside the program. The run covers arithmetic wrap past 0x7FFFFFFF, a store followed by a load of the same word, and a negative offset on a store. It covers taken and untaken branches, rejected function codes and shift fields, an unknown opcode, and a reset in the middle of the run that must keep the loaded data.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    typedef enum logic [5:0] {
        OPC_REG   = 6'h00,
        OPC_LOAD  = 6'h23,
        OPC_STORE = 6'h2B,
        OPC_BEQ   = 6'h04
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_op_e;

    // fixed slicing of an instruction word
    typedef struct packed {
        logic [5:0] opc;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] fn;
    } ifields_t;

    typedef struct packed {
        logic    rf_we;
        logic    dst_rd;
        logic    dm_we;
        logic    wb_mem;
        logic    is_beq;
        logic    b_imm;
        alu_op_e op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
    import rdp_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [4:0] shamt,
    input  logic [5:0] fn,
    output ctrl_t      ctl
);
    always_comb begin
        ctl    = '0;
        ctl.op = ALU_ADD;
        case (opc)
            OPC_REG: begin
                ctl.dst_rd = 1'b1;
                if (shamt == '0) begin
                    case (fn)
                        FN_ADD:  begin ctl.rf_we = 1'b1; ctl.op = ALU_ADD; end
                        FN_SUB:  begin ctl.rf_we = 1'b1; ctl.op = ALU_SUB; end
                        FN_AND:  begin ctl.rf_we = 1'b1; ctl.op = ALU_AND; end
                        FN_OR:   begin ctl.rf_we = 1'b1; ctl.op = ALU_OR;  end
                        default: ctl.rf_we = 1'b0;
                    endcase
                end
            end
            OPC_LOAD: begin
                ctl.rf_we  = 1'b1;
                ctl.b_imm  = 1'b1;
                ctl.wb_mem = 1'b1;
            end
            OPC_STORE: begin
                ctl.dm_we = 1'b1;
                ctl.b_imm = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_beq = 1'b1;
                ctl.op     = ALU_SUB;
            end
            default: ctl.rf_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdp_regfile.sv
module rdp_regfile
    import rdp_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] ra_a,
    output logic [W-1:0]         rd_a,
    input  logic [$clog2(N)-1:0] ra_b,
    output logic [W-1:0]         rd_b,
    input  logic [$clog2(N)-1:0] ra_o,
    output logic [W-1:0]         rd_o
);
    localparam int AW = $clog2(N);

    logic [W-1:0] cells [N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        if (i == 0) begin : g_zero
            assign cells[i] = '0;
        end else begin : g_ff
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && waddr == AW'(i))
                    q <= wdata;
            end
            assign cells[i] = q;
        end
    end

    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];
    assign rd_o = cells[ra_o];
endmodule

// File: rtl/rdp_alu.sv
module rdp_alu
    import rdp_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/rdp_core.sv
module rdp_core
    import rdp_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ld_en,
    input  logic                         ld_dmem,
    input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
    input  logic [XLEN-1:0]              ld_data,
    input  logic [RAW-1:0]               obs_sel,
    output logic [XLEN-1:0]              obs_data,
    output logic [XLEN-1:0]              pc
);
    localparam int MAW = $clog2(MEM_WORDS);

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] instr;
    ifields_t        f;
    ctrl_t           ctl;
    logic [XLEN-1:0] imm_ext;
    logic [RAW-1:0]  rf_waddr;
    logic            rf_we;
    logic [XLEN-1:0] rs_val, rt_val, wb_data;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic [MAW-1:0]  dm_idx;
    logic [XLEN-1:0] dm_rdata;
    logic            dm_we;
    logic [XLEN-1:0] pc_inc, br_tgt, pc_next;

    // fetch and slice
    assign instr   = imem[pc[MAW+1:2]];
    assign f       = ifields_t'(instr);
    assign imm_ext = sext16(instr[15:0]);

    rdp_ctrl u_ctrl (
        .opc   (f.opc),
        .shamt (f.shamt),
        .fn    (f.fn),
        .ctl   (ctl)
    );

    assign rf_we    = ctl.rf_we;
    assign rf_waddr = ctl.dst_rd ? f.rd : f.rt;

    rdp_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (wb_data),
        .ra_a  (f.rs),
        .rd_a  (rs_val),
        .ra_b  (f.rt),
        .rd_b  (rt_val),
        .ra_o  (obs_sel),
        .rd_o  (obs_data)
    );

    assign alu_b = ctl.b_imm ? imm_ext : rt_val;

    rdp_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctl.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data array: word indexed by the effective address
    assign dm_idx   = alu_y[MAW+1:2];
    assign dm_rdata = dmem[dm_idx];
    assign dm_we    = ctl.dm_we;
    assign wb_data  = ctl.wb_mem ? dm_rdata : alu_y;

    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem)
            imem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem)
            dmem[ld_addr] <= ld_data;
        else if (dm_we && !rst)
            dmem[dm_idx] <= rt_val;
    end

    // next PC
    assign pc_inc  = pc + XLEN'(4);
    assign br_tgt  = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
    assign pc_next = (ctl.is_beq && alu_zero) ? br_tgt : pc_inc;

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else
            pc <= pc_next;
    end
endmodule

// File: rtl/rdp_checker.sv
module rdp_checker
    import rdp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            rf_we,
    input logic            dm_we,
    input logic [RAW-1:0]  obs_sel,
    input logic [XLEN-1:0] obs_data
);
    logic [5:0]      opc;
    logic [XLEN-1:0] tgt_taken;
    logic            known_opc;
    logic            good_fn;

    assign opc       = instr[31:26];
    assign tgt_taken = pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign known_opc = (opc == 6'h00) || (opc == 6'h23) || (opc == 6'h2B) || (opc == 6'h04);
    assign good_fn   = (instr[10:6] == 5'd0) &&
                       (instr[5:0] == 6'h20 || instr[5:0] == 6'h22 ||
                        instr[5:0] == 6'h24 || instr[5:0] == 6'h25);

    assert_pc_cleared_R1: assert property (@(posedge clk)
        rst |=> pc == 32'd0);

    assert_seq_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'h04) |=> pc == $past(pc) + 32'd4);

    assert_branch_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h04 && rs_val == rt_val) |=> pc == $past(tgt_taken));

    assert_branch_fallthru_R8: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h04 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (rst)
        (obs_sel == '0) |-> obs_data == '0);

    assert_bad_fn_R5: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h00 && !good_fn) |-> !rf_we);

    assert_store_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h2B) |-> (!rf_we && dm_we));

    assert_unknown_inert_R9: assert property (@(posedge clk) disable iff (rst)
        !known_opc |-> (!rf_we && !dm_we));
endmodule

bind rdp_core rdp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .rf_we    (rf_we),
    .dm_we    (dm_we),
    .obs_sel  (obs_sel),
    .obs_data (obs_data)
);

// File: tb/rdp_core_test.sv
`timescale 1ns/10ps
module rdp_core_test;
    localparam int WORDS = 64;
    localparam int NPROG = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  obs_sel = '0;
    logic [31:0] obs_data;
    logic [31:0] pc;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rdp_core #(.MEM_WORDS(WORDS)) uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .obs_sel(obs_sel),
        .obs_data(obs_data), .pc(pc)
    );

    // program: word index -> instruction
    localparam logic [31:0] PROG [NPROG] = '{
        32'h8C410064, // 0  load r1 <- [r2+100]
        32'h8C030000, // 1  load r3 <- [0]
        32'h8C040004, // 2  load r4 <- [4]
        32'h00642820, // 3  r5 = r3 + r4 (wraps past 0x7FFFFFFF)
        32'h00643022, // 4  r6 = r3 - r4
        32'h00243824, // 5  r7 = r1 & r4
        32'h00234025, // 6  r8 = r1 | r3
        32'h00210020, // 7  r0 = r1 + r1, dropped
        32'hAC050008, // 8  store r5 -> [8]
        32'h8C090008, // 9  load r9 <- [8]
        32'h10230002, // 10 branch r1==r3, not taken
        32'h8C0A000C, // 11 load r10 <- [12]
        32'h8C0C000C, // 12 load r12 <- [12]
        32'h114C0002, // 13 branch r10==r12 forward to 16
        32'h00215820, // 14 skipped
        32'h00215820, // 15 skipped
        32'hAD41FFFC, // 16 store r1 -> [r10-4]
        32'h8C0D003C, // 17 load r13 <- [60]
        32'h00215827, // 18 unsupported funct
        32'h00215860, // 19 add with nonzero shamt
        32'h3C0B1234, // 20 unknown opcode
        32'h114CFFF0  // 21 branch back -16 words to 6
    };

    // behavioural reference state
    logic [31:0] m_pc;
    logic [31:0] m_reg  [32];
    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    string       tag;

    function automatic logic [31:0] dinit(int i);
        case (i)
            0:       return 32'd5;
            1:       return 32'h7FFFFFFF;
            3:       return 32'h00000040;
            25:      return 32'h12345678;
            default: return 32'd0;
        endcase
    endfunction

    task automatic note(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic put(int dst, logic [31:0] v, string req);
        if (dst == 0) tag = "R2";
        else begin m_reg[dst] = v; tag = req; end
    endtask

    task automatic model_step();
        logic [31:0] ins, a, b, sx, ea, nxt;
        int rs, rt, rd;
        ins = m_imem[m_pc[7:2]];
        rs  = int'(ins[25:21]);
        rt  = int'(ins[20:16]);
        rd  = int'(ins[15:11]);
        a   = m_reg[rs];
        b   = m_reg[rt];
        sx  = {{16{ins[15]}}, ins[15:0]};
        ea  = a + sx;
        nxt = m_pc + 32'd4;
        if (rst) begin
            m_pc = 32'd0;
            for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
            tag = "R1";
            return;
        end
        tag = "R9";
        case (ins[31:26])
            6'h00: begin
                tag = "R5";
                if (ins[10:6] == 5'd0) begin
                    case (ins[5:0])
                        6'h20: put(rd, a + b, "R4");
                        6'h22: put(rd, a - b, "R4");
                        6'h24: put(rd, a & b, "R4");
                        6'h25: put(rd, a | b, "R4");
                        default: tag = "R5";
                    endcase
                end
            end
            6'h23: put(rt, m_dmem[ea[7:2]], "R6");
            6'h2B: begin m_dmem[ea[7:2]] = b; tag = "R7"; end
            6'h04: begin
                tag = "R8";
                if (a == b) nxt = m_pc + 32'd4 + (sx << 2);
            end
            default: tag = "R9";
        endcase
        m_pc = nxt;
    endtask

    // compare PC and every register through the observation port
    task automatic compare_all();
        note(pc === m_pc, tag, "R3/R8 pc", pc, m_pc);
        for (int r = 0; r < 32; r++) begin
            obs_sel = 5'(r);
            #0.1;
            note(obs_data === m_reg[r], tag, $sformatf("R11 reg%0d", r), obs_data, m_reg[r]);
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        m_pc = 32'd0;
        tag  = "R1";
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        // R10: fill both arrays through the load port while reset is held
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_dmem = 1'b0;
            ld_addr = 6'(i);
            ld_data = (i < NPROG) ? PROG[i] : 32'd0;
            m_imem[i] = ld_data;
            @(negedge clk);
            ld_dmem = 1'b1;
            ld_data = dinit(i);
            m_dmem[i] = ld_data;
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        tag = "R1";
        compare_all();
        rst = 1'b0;

        // first instruction loads the preloaded word 25 into r1
        run(1);
        obs_sel = 5'd1;
        #0.1;
        note(obs_data === 32'h12345678, "R10", "loaded word via r1", obs_data, 32'h12345678);

        run(70);

        // reset mid-run: registers and PC clear, arrays survive
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(40);
        obs_sel = 5'd13;
        #0.1;
        note(obs_data === 32'h12345678, "R7", "store at negative offset survives reset", obs_data, 32'h12345678);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog run did not complete actual=%08h expected=%08h", pc, m_pc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule